// File: doc/BRIEF.md
# Link Speed Monitor and Activity LED Controller

This block watches a PHY over a management-bus request port and turns what it learns into a tri-colour network LED. At a fixed interval it reads the PHY's basic status register at address 1. If the link bit there is set, it then reads the auxiliary register at 0x18 to learn whether the link runs at 10 or 100 Mb/s. The resulting speed is held in a register and shown on a two-bit status output. The bit-level serializer is outside the block. It sees only a request with a register number and a one-cycle acknowledge that carries the read data.

Traffic pulses make the LED flash. A flash lasts at least a minimum on time. It ends only at a periodic check instant, and a pause then follows during which new traffic cannot start another flash. Under continuous traffic the LED therefore keeps blinking visibly instead of looking steadily lit. A mode input chooses the polarity. The LED can be lit while idle and dark during a flash, or the reverse. The colour comes from the polled speed. All time is counted in `tick_i` pulses.

Top module: `linkled_ctrl`

## Requirements
- R1: After reset the speed output is 10 Mb/s (code 01), no flash is in progress and no request is raised. The first status request appears exactly POLL_TICKS ticks after reset is released.
- R2: Every request uses PHY address 0 and register 1 or 0x18. A request stays raised until it is acknowledged.
- R3: A status read whose bit 2 is clear sets the speed to link down (code 00) and issues no auxiliary read. A status read whose bit 2 is set is followed by a read of register 0x18.
- R4: An auxiliary read with bit 1 set gives 100 Mb/s (code 10). With bit 1 clear it gives 10 Mb/s (code 01). The speed code 11 never appears.
- R5: While the speed is link down, the LED code is red (01), whatever the activity and mode.
- R6: With the link up, a lit LED is orange (10) at 10 Mb/s and green (11) at 100 Mb/s. An unlit LED is off (00).
- R7: With `lit_on_act_i` low the LED is lit while idle and unlit during a flash. With it high the polarity is reversed, and a change of the input takes effect at once.
- R8: An activity pulse starts a flash at the next clock edge only if no flash is in progress and the pause has run out. Activity during a flash neither extends nor restarts it.
- R9: A flash ends only at a check instant, which comes every CHECK_TICKS ticks, and only once ON_TICKS ticks have passed since the flash started. For PAUSE_TICKS ticks after it ends, activity is ignored.
- R10: At the edge that records a changed speed, any flash in progress is cancelled, so the LED shows its idle state at once.
- R11: After each poll completes, the next status request rises exactly POLL_TICKS ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base pulse; all intervals are counted in these |
| act_i | input | 1 | Receive/transmit activity pulse |
| lit_on_act_i | input | 1 | 0: lit when idle; 1: lit during a flash |
| mdio_req_o | output | 1 | Read request to the management serializer |
| mdio_phy_o | output | 5 | PHY address of the request (always 0) |
| mdio_reg_o | output | 5 | Register number of the request |
| mdio_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| mdio_rdata_i | input | 16 | Register read data |
| speed_o | output | 2 | 00 down, 01 10 Mb/s, 10 100 Mb/s |
| led_o | output | 2 | 00 off, 01 red, 10 orange, 11 green |

## Verification
The bench builds the block with POLL_TICKS=32, ON_TICKS=12, PAUSE_TICKS=3 and CHECK_TICKS=4, and holds the tick high on every cycle. With these values a whole poll interval spans a few dozen cycles, so repeated polls, the exact first-request cycle and the interval between polls can all be observed. The flash minimum, the clear window at the check instants and the pause can each be resolved edge by edge. Because the poll takes far fewer cycles than the minimum flash, a flash can be started at a request and still be in progress when a changed speed is recorded.

// File: rtl/linkled_pkg.sv
package linkled_pkg;

    typedef enum logic [1:0] {
        SPD_DOWN = 2'd0,
        SPD_10   = 2'd1,
        SPD_100  = 2'd2
    } speed_e;

    typedef enum logic [1:0] {
        LED_OFF    = 2'd0,
        LED_RED    = 2'd1,
        LED_ORANGE = 2'd2,
        LED_GREEN  = 2'd3
    } led_e;

    typedef enum logic [1:0] {
        PS_WAIT = 2'd0,
        PS_STAT = 2'd1,
        PS_AUX  = 2'd2
    } poll_state_e;

    localparam logic [4:0] PHY_ADDR   = 5'd0;
    localparam logic [4:0] REG_STATUS = 5'd1;
    localparam logic [4:0] REG_AUX    = 5'h18;
    localparam int         LINK_BIT   = 2;
    localparam int         SPEED_BIT  = 1;

    // Colour for a given speed and lit state; link down overrides everything.
    function automatic led_e pick_colour(input speed_e spd, input logic lit);
        led_e c;
        if (spd == SPD_DOWN)      c = LED_RED;
        else if (!lit)            c = LED_OFF;
        else if (spd == SPD_100)  c = LED_GREEN;
        else                      c = LED_ORANGE;
        return c;
    endfunction

endpackage

// File: rtl/linkled_poll.sv
module linkled_poll
    import linkled_pkg::*;
#(
    parameter int POLL_TICKS = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        ack_i,
    input  logic        link_up_i,
    input  logic        fast_i,
    output logic        req_o,
    output logic [4:0]  reg_o,
    output speed_e      speed_o,
    output logic        chg_o
);
    localparam int CW = (POLL_TICKS > 2) ? $clog2(POLL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_TICKS - 1);

    poll_state_e    state_q;
    logic [CW-1:0]  cnt_q;
    speed_e         spd_q, spd_nxt;
    logic           upd;

    always_comb begin
        spd_nxt = spd_q;
        upd     = 1'b0;
        if (state_q == PS_STAT && ack_i && !link_up_i) begin
            spd_nxt = SPD_DOWN;
            upd     = 1'b1;
        end
        if (state_q == PS_AUX && ack_i) begin
            spd_nxt = fast_i ? SPD_100 : SPD_10;
            upd     = 1'b1;
        end
    end

    assign chg_o   = upd && (spd_nxt != spd_q);
    assign req_o   = (state_q != PS_WAIT);
    assign reg_o   = (state_q == PS_AUX) ? REG_AUX : REG_STATUS;
    assign speed_o = spd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_WAIT;
            cnt_q   <= '0;
            spd_q   <= SPD_10;
        end else begin
            spd_q <= spd_nxt;
            case (state_q)
                PS_WAIT: if (tick_i) begin
                    if (cnt_q == LAST) begin
                        state_q <= PS_STAT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PS_STAT: if (ack_i) state_q <= link_up_i ? PS_AUX : PS_WAIT;
                PS_AUX:  if (ack_i) state_q <= PS_WAIT;
                default: state_q <= PS_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/linkled_flash.sv
module linkled_flash #(
    parameter int ON_TICKS    = 20,
    parameter int PAUSE_TICKS = 10,
    parameter int CHECK_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic act_i,
    input  logic clr_i,
    output logic active_o
);
    localparam int OW = $clog2(ON_TICKS + 1);
    localparam int PW = $clog2(PAUSE_TICKS + 1);
    localparam int KW = (CHECK_TICKS > 2) ? $clog2(CHECK_TICKS) : 1;
    localparam logic [KW-1:0] K_LAST = KW'(CHECK_TICKS - 1);

    logic          active_q;
    logic [OW-1:0] on_q;
    logic [PW-1:0] pause_q;
    logic [KW-1:0] chk_q;
    logic          chk_fire;

    assign chk_fire = tick_i && (chk_q == K_LAST);
    assign active_o = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            on_q     <= '0;
            pause_q  <= '0;
            chk_q    <= '0;
        end else begin
            if (tick_i) begin
                chk_q <= chk_fire ? '0 : chk_q + 1'b1;
                if (on_q != '0)    on_q    <= on_q - 1'b1;
                if (pause_q != '0) pause_q <= pause_q - 1'b1;
            end
            if (clr_i) begin
                active_q <= 1'b0;
            end else if (active_q && chk_fire && on_q == '0) begin
                active_q <= 1'b0;
                pause_q  <= PW'(PAUSE_TICKS);
            end else if (!active_q && act_i && pause_q == '0) begin
                active_q <= 1'b1;
                on_q     <= OW'(ON_TICKS);
            end
        end
    end
endmodule

// File: rtl/linkled_colour.sv
module linkled_colour
    import linkled_pkg::*;
(
    input  speed_e spd_i,
    input  logic   active_i,
    input  logic   lit_on_act_i,
    output led_e   led_o
);
    logic lit;
    assign lit   = lit_on_act_i ? active_i : !active_i;
    assign led_o = pick_colour(spd_i, lit);
endmodule

// File: rtl/linkled_ctrl.sv
module linkled_ctrl
    import linkled_pkg::*;
#(
    parameter int POLL_TICKS  = 2000,
    parameter int ON_TICKS    = 20,
    parameter int PAUSE_TICKS = 10,
    parameter int CHECK_TICKS = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        act_i,
    input  logic        lit_on_act_i,
    output logic        mdio_req_o,
    output logic [4:0]  mdio_phy_o,
    output logic [4:0]  mdio_reg_o,
    input  logic        mdio_ack_i,
    input  logic [15:0] mdio_rdata_i,
    output logic [1:0]  speed_o,
    output logic [1:0]  led_o
);
    speed_e spd;
    led_e   colour;
    logic   spd_chg;
    logic   flash_on;
    logic   unused_rdata_bits;

    assign unused_rdata_bits = ^{mdio_rdata_i[15:3], mdio_rdata_i[0]};

    linkled_poll #(.POLL_TICKS(POLL_TICKS)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .ack_i     (mdio_ack_i),
        .link_up_i (mdio_rdata_i[LINK_BIT]),
        .fast_i    (mdio_rdata_i[SPEED_BIT]),
        .req_o     (mdio_req_o),
        .reg_o     (mdio_reg_o),
        .speed_o   (spd),
        .chg_o     (spd_chg)
    );

    linkled_flash #(
        .ON_TICKS    (ON_TICKS),
        .PAUSE_TICKS (PAUSE_TICKS),
        .CHECK_TICKS (CHECK_TICKS)
    ) u_flash (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .act_i    (act_i),
        .clr_i    (spd_chg),
        .active_o (flash_on)
    );

    linkled_colour u_colour (
        .spd_i        (spd),
        .active_i     (flash_on),
        .lit_on_act_i (lit_on_act_i),
        .led_o        (colour)
    );

    assign mdio_phy_o = PHY_ADDR;
    assign speed_o    = spd;
    assign led_o      = colour;
endmodule

// File: rtl/linkled_ctrl_chk.sv
module linkled_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       lit_on_act_i,
    input logic       mdio_req_o,
    input logic       mdio_ack_i,
    input logic       link_bit,
    input logic [4:0] mdio_phy_o,
    input logic [4:0] mdio_reg_o,
    input logic [1:0] speed_o,
    input logic [1:0] led_o
);
    assert_down_red_R5: assert property (@(posedge clk) disable iff (rst)
        speed_o == 2'd0 |-> led_o == 2'd1);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        mdio_req_o && !mdio_ack_i |=> mdio_req_o);

    assert_req_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mdio_req_o |-> mdio_phy_o == 5'd0 && (mdio_reg_o == 5'd1 || mdio_reg_o == 5'h18));

    assert_speed_code_R4: assert property (@(posedge clk) disable iff (rst)
        speed_o != 2'd3);

    assert_aux_after_up_R3: assert property (@(posedge clk) disable iff (rst)
        (mdio_req_o && mdio_reg_o == 5'h18 &&
         !($past(mdio_req_o) && $past(mdio_reg_o) == 5'h18))
        |-> $past(mdio_ack_i) && $past(link_bit));

    assert_refresh_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (speed_o != $past(speed_o)) && speed_o != 2'd0
        |-> (lit_on_act_i ? led_o == 2'd0 : led_o != 2'd0));
endmodule

bind linkled_ctrl linkled_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lit_on_act_i (lit_on_act_i),
    .mdio_req_o   (mdio_req_o),
    .mdio_ack_i   (mdio_ack_i),
    .link_bit     (mdio_rdata_i[2]),
    .mdio_phy_o   (mdio_phy_o),
    .mdio_reg_o   (mdio_reg_o),
    .speed_o      (speed_o),
    .led_o        (led_o)
);

// File: tb/linkled_ctrl_bench.sv
module linkled_ctrl_bench;
    localparam int PERIOD = 10;
    localparam int POLL   = 32;
    localparam int ON     = 12;
    localparam int PAUSE  = 3;
    localparam int CHECK  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        act = 1'b0;
    logic        mode = 1'b0;
    logic        req;
    logic [4:0]  phy, regn;
    logic        ack = 1'b0;
    logic [15:0] rdata = '0;
    logic [1:0]  speed, led;

    logic [15:0] stat_val = 16'h0004;
    logic [15:0] aux_val  = 16'h0002;
    int          n_aux = 0;
    int          bad_addr = 0;
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    linkled_ctrl #(
        .POLL_TICKS(POLL), .ON_TICKS(ON), .PAUSE_TICKS(PAUSE), .CHECK_TICKS(CHECK)
    ) u_linkled_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick), .act_i(act), .lit_on_act_i(mode),
        .mdio_req_o(req), .mdio_phy_o(phy), .mdio_reg_o(regn),
        .mdio_ack_i(ack), .mdio_rdata_i(rdata),
        .speed_o(speed), .led_o(led)
    );

    initial forever #(PERIOD/2) clk = ~clk;

    // PHY responder: acknowledges each request two cycles after it is seen.
    initial forever begin
        @(posedge clk);
        #2;
        if (ack) begin
            ack  = 1'b0;
            wcnt = 0;
        end else if (req && !rst) begin
            if (wcnt == 2) begin
                ack = 1'b1;
                if (phy != 5'd0) bad_addr++;
                if (regn == 5'd1)       rdata = stat_val;
                else if (regn == 5'h18) begin rdata = aux_val; n_aux++; end
                else                    bad_addr++;
            end else begin
                wcnt++;
            end
        end
    end

    typedef struct packed {
        logic [15:0] stat;
        logic [15:0] aux;
        logic        md;
        logic [1:0]  spd;
        logic [1:0]  col;
        logic        aux_rd;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{16'h0004, 16'h0002, 1'b0, 2'd2, 2'd3, 1'b1},
        '{16'h0000, 16'h0002, 1'b1, 2'd0, 2'd1, 1'b0},
        '{16'hFFFB, 16'hFFFF, 1'b0, 2'd0, 2'd1, 1'b0},
        '{16'h0004, 16'hFFFD, 1'b0, 2'd1, 2'd2, 1'b1},
        '{16'h0004, 16'h0000, 1'b1, 2'd1, 2'd0, 1'b1},
        '{16'h0006, 16'h0002, 1'b1, 2'd2, 2'd0, 1'b1},
        '{16'h0004, 16'h0002, 1'b0, 2'd2, 2'd3, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string rq, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, actual, expected);
        end
    endtask

    task automatic wait_req(input logic level, output int n);
        n = 0;
        while (req !== level && n < 400) begin
            step();
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 60000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        int aux0;
        bit cleared;
        repeat (3) step();
        rst = 1'b0;

        // R1: reset state and first request timing
        check(speed == 2'd1, "R1 reset speed", speed, 1);
        check(led == 2'd2, "R1 reset led idle orange", led, 2);
        for (int k = 1; k < POLL; k++) begin
            step();
            if (req) check(1'b0, "R1 early request", k, POLL);
        end
        check(req == 1'b0, "R1 no request before interval", req, 0);
        step();
        check(req == 1'b1, "R1 first request at interval", req, 1);
        check(regn == 5'd1 && phy == 5'd0, "R2 status register request", regn, 1);
        wait_req(1'b0, n);

        // Table of polled register contents
        for (int i = 0; i < 7; i++) begin
            stat_val = VECS[i].stat;
            aux_val  = VECS[i].aux;
            mode     = VECS[i].md;
            aux0     = n_aux;
            wait_req(1'b1, n);
            wait_req(1'b0, n);
            check(speed == VECS[i].spd, "R3 R4 polled speed", speed, VECS[i].spd);
            check(led == VECS[i].col, "R5 R6 R7 idle colour", led, VECS[i].col);
            check((n_aux - aux0) == int'(VECS[i].aux_rd), "R3 aux read issued",
                  n_aux - aux0, VECS[i].aux_rd);
        end
        check(bad_addr == 0, "R2 address of requests", bad_addr, 0);

        // R11: interval between polls
        n = 0;
        while (!req && n < 400) begin
            step();
            n++;
        end
        check(n == POLL, "R11 poll interval", n, POLL);
        wait_req(1'b0, n);

        // Flash at 100 Mb/s, mode lit-on-idle, traffic held continuously
        mode = 1'b0;
        act  = 1'b1;
        for (int k = 0; k <= ON; k++) begin
            step();
            check(led == 2'd0, "R8 R9 flash held for minimum", led, 0);
            if (k == 5) begin
                mode = 1'b1;
                #1;
                check(led == 2'd3, "R7 reversed polarity during flash", led, 3);
                mode = 1'b0;
                #1;
            end
        end
        cleared = 0;
        for (int k = 0; k < CHECK && !cleared; k++) begin
            step();
            if (led == 2'd3) cleared = 1;
        end
        check(cleared, "R9 flash cleared at check instant", led, 3);
        for (int k = 0; k < PAUSE; k++) begin
            step();
            check(led == 2'd3, "R9 pause blocks new flash", led, 3);
        end
        step();
        check(led == 2'd0, "R8 flash after pause", led, 0);
        act = 1'b0;
        repeat (30) step();

        // R10: speed change cancels an ongoing flash
        stat_val = 16'h0004;
        aux_val  = 16'h0000;
        wait_req(1'b1, n);
        act = 1'b1;
        step();
        act = 1'b0;
        check(led == 2'd0, "R8 flash started", led, 0);
        wait_req(1'b0, n);
        check(speed == 2'd1, "R4 speed now 10", speed, 1);
        check(led == 2'd2, "R10 idle colour right after speed change", led, 2);
        repeat (30) step();

        // R5: link down stays red under activity in both modes
        stat_val = 16'h0000;
        wait_req(1'b1, n);
        wait_req(1'b0, n);
        check(speed == 2'd0, "R3 link down", speed, 0);
        act = 1'b1;
        step();
        act = 1'b0;
        check(led == 2'd1, "R5 red during activity", led, 1);
        mode = 1'b1;
        #1;
        check(led == 2'd1, "R5 red in other mode", led, 1);

        finish_run();
    end
endmodule